// File: doc/BRIEF.md
# DDR2 Command Decoder and Bank Tracker

This block sits behind the command pins of a DDR2-style memory interface. On each rising clock edge it samples chip select, the three command strobes, the two bank lines and the address bus. From these it decodes one command and emits it as a one-cycle pulse. It keeps an open/idle flag and the last activated row for each of four banks.

Address bit 10 means different things for different commands. On a read or write it requests auto-precharge and is dropped from the column. On a precharge it chooses between closing one bank and closing every bank. During a mode-register write, the bank lines choose which register is loaded instead of choosing a bank. Sequences that break the bank state rules are not executed. They raise an error pulse instead, so a controller model or a protocol monitor can use the block as a reference tracker.

All outputs are registered. A command sampled at edge k shows its pulse, addresses and updated bank state in the cycle that follows edge k.

Top module: `ddr2_cmd_tracker`

## Requirements
- R1: When csN is sampled high, no command pulse and no error pulse follow, and bank state is unchanged.
- R2: With csN low, {rasN,casN,weN} decodes as follows: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode-register write. The codes 111 and 110 do nothing. Each accepted command gives exactly one pulse in the cycle after its sampling edge.
- R3: An accepted activate marks bank ba open. It stores addr[13:0] as that bank's open row at openRows[14*ba +: 14], and also presents the row on rowAddr and the bank on cmdBank.
- R4: An accepted read or write presents column {addr[11], addr[9:0]} on colAddr and addr[10] on autoPre. When addr[10] is 1, the bank becomes idle.
- R5: A precharge with addr[10]=0 pulses prePulse and closes only bank ba. With addr[10]=1 it pulses preAllPulse and closes all banks. A precharge to a bank that is already idle is accepted and changes nothing.
- R6: A mode-register write with ba=0 pulses mrsPulse. Any other ba value pulses emrsPulse. In both cases mrSel shows the ba value.
- R7: A read or write to an idle bank, or an activate to an open bank, pulses seqErr instead of the command pulse and leaves bankOpen and openRows unchanged.
- R8: A refresh or mode-register write while any bank is open pulses seqErr instead of the command pulse.
- R9: With IS_X16 set, row bit 13 is ignored and is always stored and presented as 0.
- R10: After reset, all banks are idle, all open rows are zero and no pulses are active.
- R11: In any cycle, at most one of the eight command pulses and seqErr is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs sampled on rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | 2 | Bank index or mode-register selector |
| addr | input | 14 | Row, column/auto-precharge or opcode |
| actPulse | output | 1 | Activate accepted |
| rdPulse | output | 1 | Read accepted |
| wrPulse | output | 1 | Write accepted |
| prePulse | output | 1 | Single-bank precharge accepted |
| preAllPulse | output | 1 | All-bank precharge accepted |
| refPulse | output | 1 | Refresh accepted |
| mrsPulse | output | 1 | Base mode-register write accepted |
| emrsPulse | output | 1 | Extended mode-register write accepted |
| seqErr | output | 1 | Illegal sequence rejected |
| mrSel | output | 2 | Register chosen by the last accepted mode write |
| cmdBank | output | 2 | Bank of the last accepted bank command |
| rowAddr | output | 14 | Row of the last accepted activate |
| colAddr | output | 11 | Column of the last accepted read or write |
| autoPre | output | 1 | Auto-precharge flag of the last read or write |
| bankOpen | output | 4 | Open flag per bank |
| openRows | output | 56 | Open row per bank, 14 bits each, bank 0 lowest |

## Verification
The assertions assume that reset is applied before the first command and that the command inputs are stable around each rising edge. Under those conditions, one registered pulse per cycle and the bank flags following the strobes are expected to hold. The stimulus changes inputs only on falling edges and issues at most one command per cycle. It steers the bank state through every legal and illegal transition, including precharge to an idle bank, so that every error path is reached while the invariants still hold.

// File: rtl/ddr2_cmd_pkg.sv
package ddr2_cmd_pkg;

  typedef enum logic [3:0] {
    CMD_DESEL,
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_REF,
    CMD_MODE
  } cmdKind_t;

  // strobes from control to the bank datapath
  typedef struct packed {
    logic openBank;
    logic closeBank;
    logic closeAll;
    logic latchCol;
  } bankStb_t;

endpackage

// File: rtl/ddr2_cmd_ctrl.sv
module ddr2_cmd_ctrl
  import ddr2_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BA_W-1:0]      ba,
  input  logic                 apFlag,
  input  logic [NUM_BANKS-1:0] bankOpen,
  output bankStb_t             stb,
  output logic                 actPulse,
  output logic                 rdPulse,
  output logic                 wrPulse,
  output logic                 prePulse,
  output logic                 preAllPulse,
  output logic                 refPulse,
  output logic                 mrsPulse,
  output logic                 emrsPulse,
  output logic                 seqErr,
  output logic [BA_W-1:0]      mrSel
);

  cmdKind_t kind;
  logic     legal;
  logic     isOpen;
  logic     anyOpen;

  assign isOpen  = bankOpen[ba];
  assign anyOpen = |bankOpen;

  always_comb begin
    if (csN) begin
      kind = CMD_DESEL;
    end else begin
      unique case ({rasN, casN, weN})
        3'b011:  kind = CMD_ACT;
        3'b101:  kind = CMD_RD;
        3'b100:  kind = CMD_WR;
        3'b010:  kind = CMD_PRE;
        3'b001:  kind = CMD_REF;
        3'b000:  kind = CMD_MODE;
        default: kind = CMD_NOP;
      endcase
    end
  end

  always_comb begin
    unique case (kind)
      CMD_ACT:           legal = !isOpen;
      CMD_RD, CMD_WR:    legal = isOpen;
      CMD_REF, CMD_MODE: legal = !anyOpen;
      default:           legal = 1'b1;
    endcase
  end

  always_comb begin
    stb           = '0;
    stb.openBank  = legal && (kind == CMD_ACT);
    stb.latchCol  = legal && ((kind == CMD_RD) || (kind == CMD_WR));
    stb.closeBank = (stb.latchCol && apFlag) || ((kind == CMD_PRE) && !apFlag);
    stb.closeAll  = (kind == CMD_PRE) && apFlag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actPulse    <= 1'b0;
      rdPulse     <= 1'b0;
      wrPulse     <= 1'b0;
      prePulse    <= 1'b0;
      preAllPulse <= 1'b0;
      refPulse    <= 1'b0;
      mrsPulse    <= 1'b0;
      emrsPulse   <= 1'b0;
      seqErr      <= 1'b0;
      mrSel       <= '0;
    end else begin
      actPulse    <= legal && (kind == CMD_ACT);
      rdPulse     <= legal && (kind == CMD_RD);
      wrPulse     <= legal && (kind == CMD_WR);
      prePulse    <= (kind == CMD_PRE) && !apFlag;
      preAllPulse <= (kind == CMD_PRE) && apFlag;
      refPulse    <= legal && (kind == CMD_REF);
      mrsPulse    <= legal && (kind == CMD_MODE) && (ba == '0);
      emrsPulse   <= legal && (kind == CMD_MODE) && (ba != '0);
      seqErr      <= !legal;
      if (legal && (kind == CMD_MODE)) mrSel <= ba;
    end
  end

  // R1: a deselected cycle produces no pulse of any kind
  assert_cs_mask_R1: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !(actPulse | rdPulse | wrPulse | prePulse | preAllPulse |
              refPulse | mrsPulse | emrsPulse | seqErr));

  // R11: pulses are mutually exclusive
  assert_one_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({actPulse, rdPulse, wrPulse, prePulse, preAllPulse,
              refPulse, mrsPulse, emrsPulse, seqErr}));

  // R8: refresh is only ever reported when every bank was idle
  assert_ref_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rasN && !casN && weN && anyOpen) |=> !refPulse);

endmodule

// File: rtl/ddr2_bank_dp.sv
module ddr2_bank_dp
  import ddr2_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2,
  parameter int ADDR_W    = 14,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 11,
  parameter int AP_BIT    = 10,
  parameter bit IS_X16    = 1'b0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  bankStb_t                   stb,
  input  logic [BA_W-1:0]            ba,
  input  logic [ADDR_W-1:0]          addr,
  output logic [NUM_BANKS-1:0]       bankOpen,
  output logic [NUM_BANKS*ROW_W-1:0] openRows,
  output logic [BA_W-1:0]            cmdBank,
  output logic [ROW_W-1:0]           rowAddr,
  output logic [COL_W-1:0]           colAddr,
  output logic                       autoPre
);

  logic [ROW_W-1:0] rowIn;
  logic [COL_W-1:0] colIn;

  generate
    if (IS_X16) begin : g_rowNarrow
      assign rowIn = {1'b0, addr[ROW_W-2:0]};
    end else begin : g_rowFull
      assign rowIn = addr[ROW_W-1:0];
    end
  endgenerate

  // column skips the auto-precharge bit
  assign colIn = {addr[COL_W:AP_BIT+1], addr[AP_BIT-1:0]};

  generate
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          bankOpen[g]                 <= 1'b0;
          openRows[g*ROW_W +: ROW_W]  <= '0;
        end else if (stb.closeAll) begin
          bankOpen[g]                 <= 1'b0;
        end else if (ba == BA_W'(g)) begin
          if (stb.openBank) begin
            bankOpen[g]                <= 1'b1;
            openRows[g*ROW_W +: ROW_W] <= rowIn;
          end else if (stb.closeBank) begin
            bankOpen[g]                <= 1'b0;
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdBank <= '0;
      rowAddr <= '0;
      colAddr <= '0;
      autoPre <= 1'b0;
    end else begin
      if (stb.openBank || stb.latchCol || stb.closeBank) cmdBank <= ba;
      if (stb.openBank) rowAddr <= rowIn;
      if (stb.latchCol) begin
        colAddr <= colIn;
        autoPre <= addr[AP_BIT];
      end
    end
  end

  // R3: an open strobe leaves the addressed bank open
  assert_open_after_act_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.openBank |=> bankOpen[$past(ba)]);

  // R5: all-bank close empties every bank
  assert_close_all_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.closeAll |=> (bankOpen == '0));

endmodule

// File: rtl/ddr2_cmd_tracker.sv
module ddr2_cmd_tracker
  import ddr2_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 14,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 11,
  parameter int AP_BIT    = 10,
  parameter bit IS_X16    = 1'b0,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       csN,
  input  logic                       rasN,
  input  logic                       casN,
  input  logic                       weN,
  input  logic [BA_W-1:0]            ba,
  input  logic [ADDR_W-1:0]          addr,
  output logic                       actPulse,
  output logic                       rdPulse,
  output logic                       wrPulse,
  output logic                       prePulse,
  output logic                       preAllPulse,
  output logic                       refPulse,
  output logic                       mrsPulse,
  output logic                       emrsPulse,
  output logic                       seqErr,
  output logic [BA_W-1:0]            mrSel,
  output logic [BA_W-1:0]            cmdBank,
  output logic [ROW_W-1:0]           rowAddr,
  output logic [COL_W-1:0]           colAddr,
  output logic                       autoPre,
  output logic [NUM_BANKS-1:0]       bankOpen,
  output logic [NUM_BANKS*ROW_W-1:0] openRows
);

  bankStb_t stb;

  ddr2_cmd_ctrl #(
    .NUM_BANKS(NUM_BANKS),
    .BA_W     (BA_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .csN        (csN),
    .rasN       (rasN),
    .casN       (casN),
    .weN        (weN),
    .ba         (ba),
    .apFlag     (addr[AP_BIT]),
    .bankOpen   (bankOpen),
    .stb        (stb),
    .actPulse   (actPulse),
    .rdPulse    (rdPulse),
    .wrPulse    (wrPulse),
    .prePulse   (prePulse),
    .preAllPulse(preAllPulse),
    .refPulse   (refPulse),
    .mrsPulse   (mrsPulse),
    .emrsPulse  (emrsPulse),
    .seqErr     (seqErr),
    .mrSel      (mrSel)
  );

  ddr2_bank_dp #(
    .NUM_BANKS(NUM_BANKS),
    .BA_W     (BA_W),
    .ADDR_W   (ADDR_W),
    .ROW_W    (ROW_W),
    .COL_W    (COL_W),
    .AP_BIT   (AP_BIT),
    .IS_X16   (IS_X16)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .ba      (ba),
    .addr    (addr),
    .bankOpen(bankOpen),
    .openRows(openRows),
    .cmdBank (cmdBank),
    .rowAddr (rowAddr),
    .colAddr (colAddr),
    .autoPre (autoPre)
  );

  // R7: a rejected command leaves the bank state as it was
  assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    seqErr |-> ($stable(bankOpen) && $stable(openRows)));

endmodule

// File: tb/ddr2_cmd_tracker_tb.sv
module ddr2_cmd_tracker_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0]  ba = '0;
  logic [13:0] addr = '0;

  logic actPulse, rdPulse, wrPulse, prePulse, preAllPulse, refPulse, mrsPulse, emrsPulse, seqErr;
  logic [1:0]  mrSel, cmdBank;
  logic [13:0] rowAddr;
  logic [10:0] colAddr;
  logic        autoPre;
  logic [3:0]  bankOpen;
  logic [55:0] openRows;

  logic a16, r16, w16, p16, pa16, f16, m16, e16, err16, ap16;
  logic [1:0]  sel16, bank16;
  logic [13:0] row16;
  logic [10:0] col16;
  logic [3:0]  open16;
  logic [55:0] rows16;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr2_cmd_tracker u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .ba(ba), .addr(addr), .actPulse(actPulse), .rdPulse(rdPulse), .wrPulse(wrPulse),
    .prePulse(prePulse), .preAllPulse(preAllPulse), .refPulse(refPulse),
    .mrsPulse(mrsPulse), .emrsPulse(emrsPulse), .seqErr(seqErr), .mrSel(mrSel),
    .cmdBank(cmdBank), .rowAddr(rowAddr), .colAddr(colAddr), .autoPre(autoPre),
    .bankOpen(bankOpen), .openRows(openRows));

  ddr2_cmd_tracker #(.IS_X16(1'b1)) u_dut16 (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .ba(ba), .addr(addr), .actPulse(a16), .rdPulse(r16), .wrPulse(w16),
    .prePulse(p16), .preAllPulse(pa16), .refPulse(f16),
    .mrsPulse(m16), .emrsPulse(e16), .seqErr(err16), .mrSel(sel16),
    .cmdBank(bank16), .rowAddr(row16), .colAddr(col16), .autoPre(ap16),
    .bankOpen(open16), .openRows(rows16));

  typedef struct {
    logic [7:0]  pulses;
    logic        err;
    logic [3:0]  open;
    logic [55:0] rows;
    bit          chkRow;
    logic [13:0] row;
    bit          chkCol;
    logic [10:0] col;
    logic        ap;
    bit          chkMr;
    logic [1:0]  mr;
    bit          chkBank;
    logic [1:0]  bank;
    string       req;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  bit driverDone = 0;

  // bench model state
  logic [3:0]  mOpen = '0;
  logic [13:0] mRows [4] = '{default: '0};

  function automatic logic [7:0] outPulses();
    return {actPulse, rdPulse, wrPulse, prePulse, preAllPulse, refPulse, mrsPulse, emrsPulse};
  endfunction

  function automatic logic [55:0] packRows();
    return {mRows[3], mRows[2], mRows[1], mRows[0]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: apply one command, then push the expected result
  task automatic issue(input logic c, input logic [2:0] cmd, input logic [1:0] b,
                       input logic [13:0] a, input string req);
    exp_t e;
    @(negedge clk);
    csN = c; {rasN, casN, weN} = cmd; ba = b; addr = a;
    e = '{pulses: 8'h00, err: 1'b0, open: 4'h0, rows: '0, chkRow: 0, row: '0,
          chkCol: 0, col: '0, ap: 1'b0, chkMr: 0, mr: '0, chkBank: 0, bank: '0, req: req};
    if (!c) begin
      case (cmd)
        3'b011: if (mOpen[b]) e.err = 1'b1;
                else begin
                  mOpen[b] = 1'b1; mRows[b] = a; e.pulses = 8'h80;
                  e.chkRow = 1; e.row = a; e.chkBank = 1; e.bank = b;
                end
        3'b101, 3'b100:
                if (!mOpen[b]) e.err = 1'b1;
                else begin
                  e.pulses = (cmd == 3'b101) ? 8'h40 : 8'h20;
                  e.chkCol = 1; e.col = {a[11], a[9:0]}; e.ap = a[10];
                  e.chkBank = 1; e.bank = b;
                  if (a[10]) mOpen[b] = 1'b0;
                end
        3'b010: if (a[10]) begin e.pulses = 8'h08; mOpen = '0; end
                else begin e.pulses = 8'h10; mOpen[b] = 1'b0; e.chkBank = 1; e.bank = b; end
        3'b001: if (|mOpen) e.err = 1'b1; else e.pulses = 8'h04;
        3'b000: if (|mOpen) e.err = 1'b1;
                else begin
                  e.pulses = (b == 2'd0) ? 8'h02 : 8'h01; e.chkMr = 1; e.mr = b;
                end
        default: ;
      endcase
    end
    e.open = mOpen;
    e.rows = packRows();
    @(posedge clk);
    q.push_back(e);
  endtask

  // monitor: compare one queued expectation per cycle, away from the edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(outPulses() == e.pulses, e.req, "pulses", 64'(outPulses()), 64'(e.pulses));
        check(seqErr == e.err, e.req, "seqErr", 64'(seqErr), 64'(e.err));
        check(bankOpen == e.open, e.req, "bankOpen", 64'(bankOpen), 64'(e.open));
        check(openRows == e.rows, e.req, "openRows", 64'(openRows), 64'(e.rows));
        if (e.chkRow) check(rowAddr == e.row, e.req, "rowAddr", 64'(rowAddr), 64'(e.row));
        if (e.chkCol) begin
          check(colAddr == e.col, e.req, "colAddr", 64'(colAddr), 64'(e.col));
          check(autoPre == e.ap, e.req, "autoPre", 64'(autoPre), 64'(e.ap));
        end
        if (e.chkMr) check(mrSel == e.mr, e.req, "mrSel", 64'(mrSel), 64'(e.mr));
        if (e.chkBank) check(cmdBank == e.bank, e.req, "cmdBank", 64'(cmdBank), 64'(e.bank));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check(bankOpen == 4'h0, "R10", "bankOpen", 64'(bankOpen), 64'h0);
    check(openRows == '0, "R10", "openRows", 64'(openRows), 64'h0);
    check({outPulses(), seqErr} == 9'h0, "R10", "pulses", 64'({outPulses(), seqErr}), 64'h0);
    rstN = 1'b1;

    issue(0, 3'b011, 2'd0, 14'h1234, "R3 act b0");
    issue(0, 3'b011, 2'd0, 14'h0777, "R7 act open");
    issue(0, 3'b101, 2'd1, 14'h0001, "R7 rd idle");
    issue(0, 3'b100, 2'd2, 14'h0002, "R7 wr idle");
    issue(0, 3'b011, 2'd1, 14'h3ABC, "R3 act b1 r13");
    @(negedge clk);
    // R9: x16 variant drops row bit 13
    check(row16 == 14'h1ABC, "R9", "row16", 64'(row16), 64'h1ABC);
    check(rows16[27:14] == 14'h1ABC, "R9", "rows16", 64'(rows16[27:14]), 64'h1ABC);
    issue(0, 3'b101, 2'd0, 14'h08A5, "R4 rd b0");
    issue(0, 3'b100, 2'd1, 14'h0733, "R4 wr b1 ap");
    issue(0, 3'b001, 2'd0, 14'h0000, "R8 ref busy");
    issue(0, 3'b000, 2'd1, 14'h0040, "R8 mode busy");
    issue(1, 3'b011, 2'd2, 14'h0155, "R1 deselect");
    issue(1, 3'b010, 2'd0, 14'h0400, "R1 deselect pre");
    issue(0, 3'b111, 2'd3, 14'h0000, "R2 nop");
    issue(0, 3'b110, 2'd3, 14'h0000, "R2 code110");
    issue(0, 3'b011, 2'd2, 14'h2222, "R3 act b2");
    issue(0, 3'b011, 2'd3, 14'h0333, "R3 act b3");
    issue(0, 3'b010, 2'd2, 14'h0000, "R5 pre one");
    issue(0, 3'b010, 2'd2, 14'h0000, "R5 pre idle");
    issue(0, 3'b010, 2'd1, 14'h0400, "R5 pre all");
    issue(0, 3'b001, 2'd0, 14'h0000, "R2 ref");
    issue(0, 3'b000, 2'd0, 14'h0123, "R6 mrs");
    issue(0, 3'b000, 2'd2, 14'h0004, "R6 emrs");
    issue(0, 3'b011, 2'd3, 14'h0F0F, "R3 reopen b3");
    issue(0, 3'b101, 2'd3, 14'h0FFF, "R4 rd ap");
    issue(0, 3'b100, 2'd3, 14'h0001, "R7 wr after ap");
    issue(0, 3'b111, 2'd0, 14'h0000, "R2 tail");
    driverDone = 1;
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule